// File: doc/BRIEF.md
# Token-Ring Depth-Expansion FIFO

This block builds one deep first-in first-out buffer out of a ring of identical shallow storage slices. Two tokens travel around the ring, one for writing and one for reading. The slice that holds the write token takes every accepted write. The slice that holds the read token supplies every read. When a slice fills its last storage location, it hands the write token to the next slice in the ring. When it gives out its last location, it hands the read token on in the same way. The last slice hands back to the first, which closes the ring.

Each slice has a first-load strap. After reset, the one slice whose strap is low starts with both tokens. Because words fill the slices in ring order and drain in the same order, the chain acts as one buffer. Its capacity is the number of slices times the slice depth.

Outside the block there is one write port and one read port, on a single clock. Full comes from the slice that holds the write token, and empty comes from the slice that holds the read token. Read data is always the oldest word, shown without a read request. The positions of both tokens are also driven out as one-hot vectors.

Top module: `deep_fifo_ring`

## Requirements
- R1: After reset, `empty` is 1 and `full` is 0. `wr_owner` and `rd_owner` both equal the one-hot value with only bit FIRST_SLICE set, because that is the slice whose first-load strap is low.
- R2: At every cycle after reset, exactly one bit of `wr_owner` is set and exactly one bit of `rd_owner` is set.
- R3: Words are read out in the order they were written, across slice boundaries and across wraps of the ring.
- R4: The write token moves from slice k to slice (k+1) mod SLICES in the cycle after the SLICE_DEPTH-th accepted write since slice k received it. So after n accepted writes since reset, bit (FIRST_SLICE + n / SLICE_DEPTH) mod SLICES of `wr_owner` is set.
- R5: The read token moves the same way after every SLICE_DEPTH accepted reads. After m accepted reads, bit (FIRST_SLICE + m / SLICE_DEPTH) mod SLICES of `rd_owner` is set.
- R6: `full` is 1 exactly when SLICES*SLICE_DEPTH words are stored. A write request while `full` is 1 stores nothing and does not move the write token.
- R7: `empty` is 1 exactly when no words are stored. A read request while `empty` is 1 removes nothing and does not move the read token.
- R8: A write and a read in the same cycle are both carried out when neither flag blocks them. At full, only the read takes effect. At empty, only the write takes effect, and the written word appears on `rd_data` in the next cycle.
- R9: While `empty` is 0, `rd_data` shows the oldest stored word, taken from the slice that holds the read token, with no read request needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to store |
| full | output | 1 | Write-token slice is full |
| rd_en | input | 1 | Read request; removes the word on `rd_data` |
| rd_data | output | W | Oldest stored word, from the read-token slice |
| empty | output | 1 | Read-token slice is empty |
| wr_owner | output | SLICES | One-hot position of the write token |
| rd_owner | output | SLICES | One-hot position of the read token |

## Verification
The two functions that can land in one cycle are a write and a read. They matter most at slice boundaries, where both tokens can move on the same edge, and at the two extremes, where one flag blocks half of the pair. The bench raises both requests together in its vector table while words are in flight. It then repeats the pair on a completely full buffer and on a completely empty one. It judges every cycle against a queue model, whose token positions are computed from the running counts of accepted writes and reads. It also checks directly that only the read happens at full, and that the written word appears at empty.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  // Slice index that feeds token inputs of slice idx (ring closes at 0).
  function automatic int ring_prev(input int idx, input int n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // Slot index after idx in a storage of depth d.
  function automatic int slot_next(input int idx, input int d);
    return (idx == d - 1) ? 0 : idx + 1;
  endfunction

  // Slice expected to hold a token after 'moves' tokens-worth of transfers.
  function automatic int token_slice(input int first, input int transfers,
                                     input int depth, input int n);
    return (first + transfers / depth) % n;
  endfunction

endpackage

// File: rtl/ring_token.sv
module ring_token (
  input  logic clk,
  input  logic rst_n,
  input  logic first_load_n,
  input  logic take,
  input  logic give,
  output logic hold
);

  always_ff @(posedge clk) begin
    if (!rst_n)    hold <= ~first_load_n;
    else if (take) hold <= 1'b1;
    else if (give) hold <= 1'b0;
  end

  // R2: a token only arrives at a slice that is free or handing it on.
  a_r2_take_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!hold || give));

  // R2: only the holder can give the token away.
  a_r2_give_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> hold);

endmodule

// File: rtl/ring_slice.sv
module ring_slice #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         first_load_n,
  input  logic         wtok_in,
  output logic         wtok_out,
  input  logic         rtok_in,
  output logic         rtok_out,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         has_wtok,
  output logic         has_rtok,
  output logic         is_full,
  output logic         is_empty
);
  import ring_fifo_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP       = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  // Named internal events for assertions.
  logic do_wr, do_rd, wr_last, rd_last;

  assign do_wr   = wr_req & has_wtok;
  assign do_rd   = rd_req & has_rtok;
  assign wr_last = do_wr && (wptr == LAST_SLOT);
  assign rd_last = do_rd && (rptr == LAST_SLOT);

  assign wtok_out = wr_last;
  assign rtok_out = rd_last;

  ring_token u_wtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .take(wtok_in), .give(wr_last), .hold(has_wtok)
  );

  ring_token u_rtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .take(rtok_in), .give(rd_last), .hold(has_rtok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= AW'(slot_next(int'(wptr), DEPTH));
      if (do_rd) rptr <= AW'(slot_next(int'(rptr), DEPTH));
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  assign rd_data  = mem[rptr];
  assign is_full  = (cnt == CAP);
  assign is_empty = (cnt == '0);

  // R6: a slice never takes a write beyond its depth.
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |-> (cnt != CAP || do_rd));

  // R7: a slice never gives out a word it does not hold.
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |-> (cnt != '0));

  // R4: after handing on the write token, the next write slot is the first.
  a_r4_wptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    wtok_out |=> (wptr == '0));

  // R5: after handing on the read token, the next read slot is the first.
  a_r5_rptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    rtok_out |=> (rptr == '0));

endmodule

// File: rtl/ring_merge.sv
module ring_merge #(
  parameter int W      = 8,
  parameter int SLICES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLICES-1:0]   wtok,
  input  logic [SLICES-1:0]   rtok,
  input  logic [SLICES-1:0]   full_v,
  input  logic [SLICES-1:0]   empty_v,
  input  logic [SLICES*W-1:0] data_v,
  output logic                full,
  output logic                empty,
  output logic [W-1:0]        rd_data
);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SLICES; i++) begin
      if (rtok[i]) rd_data = rd_data | data_v[i*W +: W];
    end
  end

  assign full  = |(wtok & full_v);
  assign empty = |(rtok & empty_v);

  // R2: exactly one write token and one read token in the ring.
  a_r2_one_wtok: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok) == 1);
  a_r2_one_rtok: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok) == 1);

endmodule

// File: rtl/deep_fifo_ring.sv
module deep_fifo_ring #(
  parameter int W           = 8,
  parameter int SLICE_DEPTH = 4,
  parameter int SLICES      = 3,
  parameter int FIRST_SLICE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  output logic              empty,
  output logic [SLICES-1:0] wr_owner,
  output logic [SLICES-1:0] rd_owner
);
  import ring_fifo_pkg::*;

  logic [SLICES-1:0]   wtok_pass, rtok_pass;
  logic [SLICES-1:0]   full_v, empty_v;
  logic [SLICES*W-1:0] data_v;
  logic                wr_accept, rd_accept;

  assign wr_accept = wr_en & ~full;
  assign rd_accept = rd_en & ~empty;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = ring_prev(i, SLICES);
    localparam logic STRAP = (i == FIRST_SLICE) ? 1'b0 : 1'b1;

    ring_slice #(.W(W), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (STRAP),
      .wtok_in      (wtok_pass[PREV]),
      .wtok_out     (wtok_pass[i]),
      .rtok_in      (rtok_pass[PREV]),
      .rtok_out     (rtok_pass[i]),
      .wr_req       (wr_accept),
      .wr_data      (wr_data),
      .rd_req       (rd_accept),
      .rd_data      (data_v[i*W +: W]),
      .has_wtok     (wr_owner[i]),
      .has_rtok     (rd_owner[i]),
      .is_full      (full_v[i]),
      .is_empty     (empty_v[i])
    );
  end

  ring_merge #(.W(W), .SLICES(SLICES)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .wtok    (wr_owner),
    .rtok    (rd_owner),
    .full_v  (full_v),
    .empty_v (empty_v),
    .data_v  (data_v),
    .full    (full),
    .empty   (empty),
    .rd_data (rd_data)
  );

  // R6: a write request at full leaves the write token where it was.
  a_r6_full_holds_wtok: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_accept) |=> $stable(wr_owner));

  // R7: a read request at empty leaves the read token where it was.
  a_r7_empty_holds_rtok: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(rd_owner));

  // R6/R7: the buffer can never be full and empty at once.
  a_r6_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: tb/tb_deep_fifo_ring.sv
module tb_deep_fifo_ring;
  localparam int W     = 8;
  localparam int D     = 4;
  localparam int N     = 3;
  localparam int FIRST = 1;
  localparam int CAP   = N * D;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [W-1:0] wr_data;
  logic         full, empty;
  logic [W-1:0] rd_data;
  logic [N-1:0] wr_owner, rd_owner;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  int wr_total = 0;
  int rd_total = 0;

  always #10 clk = ~clk;

  deep_fifo_ring #(.W(W), .SLICE_DEPTH(D), .SLICES(N), .FIRST_SLICE(FIRST)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .wr_owner(wr_owner), .rd_owner(rd_owner)
  );

  // Vector: {wr, rd, data}
  localparam int NV = 22;
  localparam logic [9:0] VEC [NV] = '{
    {2'b10, 8'h11}, {2'b10, 8'h22}, {2'b10, 8'h33}, {2'b10, 8'h44},
    {2'b10, 8'h55}, {2'b11, 8'h66}, {2'b11, 8'h77}, {2'b01, 8'h00},
    {2'b11, 8'h88}, {2'b11, 8'h99}, {2'b10, 8'hA0}, {2'b10, 8'hA1},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'hA2}, {2'b10, 8'hA3},
    {2'b11, 8'hA4}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] owner_exp(input int transfers);
    logic [N-1:0] v = '0;
    v[(FIRST + transfers / D) % N] = 1'b1;
    return v;
  endfunction

  task automatic check_outputs();
    check("R6 full", 32'(full), 32'(q.size() == CAP));
    check("R7 empty", 32'(empty), 32'(q.size() == 0));
    if (q.size() > 0) check("R3/R9 rd_data", 32'(rd_data), 32'(q[0]));
    check("R4 wr_owner", 32'(wr_owner), 32'(owner_exp(wr_total)));
    check("R5 rd_owner", 32'(rd_owner), 32'(owner_exp(rd_total)));
    check("R2 one wtok", $countones(wr_owner), 1);
    check("R2 one rtok", $countones(rd_owner), 1);
  endtask

  task automatic step(input bit w, input bit r, input logic [W-1:0] d);
    bit acc_w, acc_r;
    check_outputs();
    acc_w = w && (q.size() < CAP);
    acc_r = r && (q.size() > 0);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk); #1;
    if (acc_r) begin void'(q.pop_front()); rd_total++; end
    if (acc_w) begin q.push_back(d); wr_total++; end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete(); wr_total = 0; rd_total = 0;
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 wr_owner", 32'(wr_owner), 32'(1 << FIRST));
    check("R1 rd_owner", 32'(rd_owner), 32'(1 << FIRST));
  endtask

  initial begin
    logic [N-1:0] wo, ro;
    do_reset();

    for (int i = 0; i < NV; i++) step(VEC[i][9], VEC[i][8], VEC[i][7:0]);
    check_outputs();

    // Directed: fill completely, crossing every slice boundary (R4, R6).
    do_reset();
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, W'(8'hC0 + i));
    check("R6 full at capacity", 32'(full), 1);
    wo = wr_owner;
    step(1'b1, 1'b0, 8'hEE);  // ignored write
    check("R6 wtok unmoved at full", 32'(wr_owner), 32'(wo));
    check("R6 rd_data unchanged", 32'(rd_data), 32'(8'hC0));

    // Simultaneous at full: only the read happens (R8).
    step(1'b1, 1'b1, 8'hEF);
    check("R8 full cleared by read", 32'(full), 0);
    check("R8 next word after read", 32'(rd_data), 32'(8'hC1));

    // Drain everything, checking order (R3, R5).
    while (q.size() > 0) step(1'b0, 1'b1, 8'h00);
    check("R7 empty after drain", 32'(empty), 1);
    ro = rd_owner;
    step(1'b0, 1'b1, 8'h00);  // ignored read
    check("R7 rtok unmoved at empty", 32'(rd_owner), 32'(ro));
    check("R7 still empty", 32'(empty), 1);

    // Simultaneous at empty: only the write happens (R8).
    step(1'b1, 1'b1, 8'h5A);
    check("R8 empty cleared by write", 32'(empty), 0);
    check("R8 written word visible", 32'(rd_data), 32'(8'h5A));

    // Wrap the ring a second time with interleaved traffic (R3, R4, R5).
    for (int i = 0; i < 2 * CAP; i++) step(1'b1, (i % 3) != 0, W'(i * 7));
    while (q.size() > 0) step(1'b0, 1'b1, 8'h00);
    check_outputs();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule